// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block performs integer multiplication for an execution pipeline. One opcode selects among five operations: a truncated multiply, a multiply with a 32-bit addend, unsigned and signed long multiplies, and an unsigned long multiply that adds a 64-bit accumulator. Long results come back as a low word and a high word, each with its own write-enable. A caller raises `start` for one cycle with the opcode and operands. The block captures them and returns the result together with a one-cycle `done` pulse.

For long accumulation, the 64-bit accumulator comes from two 32-bit inputs. `acc_lo` is the current value of the low destination and `acc_hi` is the current value of the high destination. For the short multiply-add, `acc_lo` is the 32-bit addend. Opcodes that have no operation assigned raise `illegal` in place of a write. Zero and negative indicators come with every legal result.

Top module: `mulacc_core`

## Requirements
- R1: Opcode 3'b000 returns the low 32 bits of `src_a`×`src_b` on `res_lo` with `res_hi` = 0. Only `we_lo` is raised, together with `done`.
- R2: Opcode 3'b001 returns the low 32 bits of `src_a`×`src_b` + `acc_lo` on `res_lo` with `res_hi` = 0. Only `we_lo` is raised.
- R3: Opcode 3'b100 forms the unsigned 64-bit product and places bits 31:0 on `res_lo` and bits 63:32 on `res_hi`. Both `we_lo` and `we_hi` are raised.
- R4: Opcode 3'b110 sign-extends both operands from 32 bits and forms the signed 64-bit product, split as in R3. Both write-enables are raised.
- R5: Opcode 3'b111 returns the unsigned product plus {`acc_hi`,`acc_lo`}, wrapping modulo 2^64, split as in R3. Both write-enables are raised.
- R6: Opcodes 3'b010, 3'b011 and 3'b101 raise `illegal` with `done`. Both write-enables stay low, and `res_lo`, `res_hi`, `flag_zero` and `flag_neg` read 0.
- R7: A `start` sampled while idle makes `busy` high for exactly the next cycle. `done` is high for exactly the cycle after that, and `busy` is low during the `done` cycle. A `start` during the `done` cycle is accepted.
- R8: A `start` sampled while `busy` is high is ignored. It produces no extra `done`, and the result reflects the accepted request.
- R9: `flag_zero` and `flag_neg` describe the written result. For R1 and R2 they use the 32-bit `res_lo` (`flag_neg` is its bit 31). For R3 to R5 they use the 64-bit {`res_hi`,`res_lo`} (`flag_neg` is bit 63).
- R10: After reset, `busy`, `done`, `we_lo`, `we_hi` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; accepted when `busy` is low |
| op | input | 3 | Operation code |
| src_a | input | 32 | First multiplicand |
| src_b | input | 32 | Second multiplicand |
| acc_lo | input | 32 | Addend for the short multiply-add; low accumulator word |
| acc_hi | input | 32 | High accumulator word |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle result-valid pulse |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |
| we_lo | output | 1 | Write-enable for the low destination, with `done` |
| we_hi | output | 1 | Write-enable for the high destination, with `done` |
| illegal | output | 1 | Unassigned opcode, with `done` |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result sign bit |

## Verification
A new request can meet the unit in two states: a result still in flight, or a result being delivered. The bench keeps `start` high through the `busy` cycle with a different opcode and operands. It then checks that only one `done` follows and that its result matches the first request. The bench also raises `start` exactly in a `done` cycle. It judges that case by the first result staying intact while the second request returns its own `done` two cycles later.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

    typedef enum logic [2:0] {
        OPC_MUL32  = 3'b000,
        OPC_MAD32  = 3'b001,
        OPC_UMUL64 = 3'b100,
        OPC_SMUL64 = 3'b110,
        OPC_UMAD64 = 3'b111
    } mul_opc_e;

    typedef struct packed {
        logic legal;
        logic wide;
        logic signed_ops;
        logic add_short;
        logic add_wide;
    } mul_ctrl_t;

    function automatic mul_ctrl_t decode_opc(input logic [2:0] code);
        mul_ctrl_t c;
        c = '0;
        case (code)
            OPC_MUL32:  c.legal = 1'b1;
            OPC_MAD32:  begin c.legal = 1'b1; c.add_short = 1'b1; end
            OPC_UMUL64: begin c.legal = 1'b1; c.wide = 1'b1; end
            OPC_SMUL64: begin c.legal = 1'b1; c.wide = 1'b1; c.signed_ops = 1'b1; end
            OPC_UMAD64: begin c.legal = 1'b1; c.wide = 1'b1; c.add_wide = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mulacc_decode.sv
module mulacc_decode
    import mulacc_pkg::*;
(
    input  logic [2:0] code,
    output mul_ctrl_t  ctrl
);
    always_comb ctrl = decode_opc(code);
endmodule

// File: rtl/mulacc_mult.sv
module mulacc_mult #(
    parameter int W = 32
) (
    input  logic           signed_ops,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    logic [PW-1:0] ax, bx;
    logic [PW-1:0] full;

    always_comb begin
        ax   = {{W{signed_ops & a[W-1]}}, a};
        bx   = {{W{signed_ops & b[W-1]}}, b};
        full = ax * bx;
        prod = full;
    end
endmodule

// File: rtl/mulacc_accum.sv
module mulacc_accum
    import mulacc_pkg::*;
#(
    parameter int W = 32
) (
    input  mul_ctrl_t      ctrl,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   acc_lo,
    input  logic [W-1:0]   acc_hi,
    output logic [W-1:0]   sum_lo,
    output logic [W-1:0]   sum_hi,
    output logic           is_zero,
    output logic           is_neg
);
    localparam int PW = 2 * W;
    logic [PW-1:0] addend, total;

    always_comb begin
        if (ctrl.add_wide)       addend = {acc_hi, acc_lo};
        else if (ctrl.add_short) addend = {{W{1'b0}}, acc_lo};
        else                     addend = '0;
        total = prod + addend;
        if (!ctrl.legal) begin
            sum_lo  = '0;
            sum_hi  = '0;
            is_zero = 1'b0;
            is_neg  = 1'b0;
        end else if (ctrl.wide) begin
            sum_lo  = total[W-1:0];
            sum_hi  = total[PW-1:W];
            is_zero = (total == '0);
            is_neg  = total[PW-1];
        end else begin
            sum_lo  = total[W-1:0];
            sum_hi  = '0;
            is_zero = (total[W-1:0] == '0);
            is_neg  = total[W-1];
        end
    end
endmodule

// File: rtl/mulacc_core.sv
module mulacc_core
    import mulacc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] acc_hi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         we_lo,
    output logic         we_hi,
    output logic         illegal,
    output logic         flag_zero,
    output logic         flag_neg
);
    localparam int PW = 2 * W;

    mul_ctrl_t     ctrl_d, ctrl_q;
    logic [W-1:0]  a_q, b_q, alo_q, ahi_q;
    logic          busy_q, done_q, we_lo_q, we_hi_q, ill_q;
    logic [W-1:0]  rlo_q, rhi_q;
    logic          z_q, n_q;
    logic [PW-1:0] prod;
    logic [W-1:0]  sum_lo, sum_hi;
    logic          is_zero, is_neg;
    logic          accept;

    assign accept = start && !busy_q;

    mulacc_decode u_dec (.code(op), .ctrl(ctrl_d));

    mulacc_mult #(.W(W)) u_mul (
        .signed_ops(ctrl_q.signed_ops), .a(a_q), .b(b_q), .prod(prod)
    );

    mulacc_accum #(.W(W)) u_acc (
        .ctrl(ctrl_q), .prod(prod), .acc_lo(alo_q), .acc_hi(ahi_q),
        .sum_lo(sum_lo), .sum_hi(sum_hi), .is_zero(is_zero), .is_neg(is_neg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctrl_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
        end else begin
            busy_q <= accept;
            if (accept) begin
                ctrl_q <= ctrl_d;
                a_q    <= src_a;
                b_q    <= src_b;
                alo_q  <= acc_lo;
                ahi_q  <= acc_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            we_lo_q <= 1'b0;
            we_hi_q <= 1'b0;
            ill_q   <= 1'b0;
            rlo_q   <= '0;
            rhi_q   <= '0;
            z_q     <= 1'b0;
            n_q     <= 1'b0;
        end else begin
            done_q  <= busy_q;
            we_lo_q <= busy_q && ctrl_q.legal;
            we_hi_q <= busy_q && ctrl_q.legal && ctrl_q.wide;
            ill_q   <= busy_q && !ctrl_q.legal;
            if (busy_q) begin
                rlo_q <= sum_lo;
                rhi_q <= sum_hi;
                z_q   <= is_zero;
                n_q   <= is_neg;
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign we_lo     = we_lo_q;
    assign we_hi     = we_hi_q;
    assign illegal   = ill_q;
    assign res_lo    = rlo_q;
    assign res_hi    = rhi_q;
    assign flag_zero = z_q;
    assign flag_neg  = n_q;
endmodule

// File: rtl/mulacc_checker.sv
module mulacc_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic we_lo,
    input logic we_hi,
    input logic illegal
);
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R7
    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done && !busy)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_BUSY_NOT_EXTENDED: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!we_lo && !we_hi && done)); // R6
    AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (we_lo || we_hi) |-> done); // R1
    AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (rst)
        we_hi |-> we_lo); // R3
    AST_DONE_CLASSIFIED: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({we_lo, illegal})); // R6
endmodule

bind mulacc_core mulacc_checker chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .we_lo(we_lo), .we_hi(we_hi), .illegal(illegal)
);

// File: tb/mulacc_core_tb_top.sv
module mulacc_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
    logic        busy, done, we_lo, we_hi, illegal, flag_zero, flag_neg;
    logic [31:0] res_lo, res_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulacc_core dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .busy(busy), .done(done),
        .res_lo(res_lo), .res_hi(res_hi), .we_lo(we_lo), .we_hi(we_hi),
        .illegal(illegal), .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        wl;
        logic        wh;
        logic        ill;
        logic        z;
        logic        n;
    } exp_t;

    function automatic exp_t model(input logic [2:0] o, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] l,
                                   input logic [31:0] h);
        exp_t e;
        logic [63:0] r;
        longint sa, sb;
        e = '0;
        case (o)
            3'd0, 3'd1: begin
                r = {32'd0, a} * {32'd0, b};
                if (o == 3'd1) r = r + {32'd0, l};
                e.lo = r[31:0]; e.wl = 1'b1;
                e.z = (r[31:0] == 0); e.n = r[31];
            end
            3'd4, 3'd6, 3'd7: begin
                if (o == 3'd6) begin
                    sa = longint'($signed(a)); sb = longint'($signed(b));
                    r = 64'(sa * sb);
                end else begin
                    r = {32'd0, a} * {32'd0, b};
                end
                if (o == 3'd7) r = r + {h, l};
                e.lo = r[31:0]; e.hi = r[63:32]; e.wl = 1'b1; e.wh = 1'b1;
                e.z = (r == 0); e.n = r[63];
            end
            default: e.ill = 1'b1;
        endcase
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd4: return "R3";
            3'd6: return "R4";
            3'd7: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] l, input logic [31:0] h);
        op = o; src_a = a; src_b = b; acc_lo = l; acc_hi = h;
    endtask

    task automatic check_result(input exp_t e, input logic [2:0] o);
        exp_t act;
        act = '{lo: res_lo, hi: res_hi, wl: we_lo, wh: we_hi, ill: illegal,
                z: flag_zero, n: flag_neg};
        check(tag_of(o), {65'd0, done, act[69:2]}, {65'd0, 1'b1, e[69:2]});
        check("R9", {126'd0, act[1:0]}, {126'd0, e[1:0]});
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] l, input logic [31:0] h);
        exp_t e;
        e = model(o, a, b, l, h);
        @(negedge clk);
        drive(o, a, b, l, h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", {127'd0, busy & ~done}, 128'd1);
        @(negedge clk);
        check("R7", {127'd0, ~busy}, 128'd1);
        check_result(e, o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e1, e2;
        logic [2:0] ro;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", {123'd0, busy, done, we_lo, we_hi, illegal}, 128'd0);

        run_op(3'd0, 32'h0001_0001, 32'h0001_0001, 0, 0);
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        run_op(3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFF1, 0);
        run_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        run_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        run_op(3'd6, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0);
        run_op(3'd6, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
        run_op(3'd7, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(3'd7, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1111_1111, 32'h2222_2222);
        run_op(3'd2, 32'h5, 32'h6, 0, 0);
        run_op(3'd3, 32'h5, 32'h6, 0, 0);
        run_op(3'd5, 32'h5, 32'h6, 0, 0);

        // R8: start held through the busy cycle with a different request
        e1 = model(3'd4, 32'h0000_0010, 32'h0000_0020, 0, 0);
        @(negedge clk);
        drive(3'd4, 32'h0000_0010, 32'h0000_0020, 0, 0);
        start = 1'b1;
        @(negedge clk);
        drive(3'd0, 32'h7, 32'h9, 0, 0);
        @(negedge clk);
        start = 1'b0;
        check_result(e1, 3'd4);
        check("R8", {126'd0, busy, done}, {126'd0, 1'b0, 1'b1});
        @(negedge clk);
        check("R8", {126'd0, busy, done}, 128'd0);

        // R7: back-to-back, second start raised in the done cycle
        e1 = model(3'd0, 32'd6, 32'd7, 0, 0);
        e2 = model(3'd7, 32'd2, 32'd3, 32'd4, 32'd1);
        @(negedge clk);
        drive(3'd0, 32'd6, 32'd7, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_result(e1, 3'd0);
        drive(3'd7, 32'd2, 32'd3, 32'd4, 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", {126'd0, busy, done}, {126'd0, 1'b1, 1'b0});
        @(negedge clk);
        check_result(e2, 3'd7);

        for (int i = 0; i < 300; i++) begin
            ro = 3'($urandom_range(0, 7));
            run_op(ro, $urandom, $urandom, $urandom, $urandom);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule